// File: doc/BRIEF.md
# Multi-Lane Sync-Sequence Deskew Buffer

This block sits behind several receive lanes that already deliver decoded 8b/10b characters on one common word clock. Each character arrives with a control flag and a running-disparity flag. The block removes the lane-to-lane skew caused by differences in trace length, cable delay and jitter. Every lane feeds a short elastic delay line. A detector on each lane watches for a four-character comma pattern. A coordinator then checks that all lanes report the pattern within a bounded window. When they do, it picks a read tap on each lane so that the characters that follow the pattern leave every lane in the same output cycle.

Cross-lane alignment works only while the word-sync enable input is high. That input is the common word-sync signal driven from a master lane. Sync points that arrive more than the window apart raise a one-cycle skew error, and the existing taps stay as they are. Selecting a new tap can drop or repeat one or two of the trailing comma characters on a lane. Downstream logic has to accept this.

Top module: `sync_deskew`

## Requirements
- R1: While reset is high and in the cycle after it falls, every output character is zero (code 0, control flag 0, disparity flag 0), `aligned` is 0 and `skew_err` is 0.
- R2: A lane reports a sync point when its four most recent characters are all commas (code 8'hBC with the control flag at 1) and their disparity flags (1 = positive) read 1,1,0,0 or 0,0,1,1 from oldest to newest. Four commas of one disparity do not form a sync point. The code 8'hBC with the control flag at 0 does not form one either.
- R3: When every lane reports a sync point no more than SKEW_SLOTS (default 1) character slots after the first lane, each lane's tap is set to the latest arrival slot minus its own arrival slot. The data that follows the sequence then appears on all lanes in the same output cycle.
- R4: `aligned` goes to 1 in the same cycle the new taps take effect, and it stays at 1 until a skew error or reset.
- R5: When the sync points are spread over more than SKEW_SLOTS slots, `skew_err` pulses high for exactly one cycle. `aligned` clears in that cycle and the taps keep their previous values. Further sync points are ignored for DEPTH slots after the pulse.
- R6: While `align_en` is 0, sync points have no effect. The taps, `aligned` and `skew_err` do not change.
- R7: A character presented at a lane input appears at that lane's output 2 + tap cycles later, and no other change is made to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common word clock |
| rst | input | 1 | Synchronous active-high reset |
| align_en | input | 1 | Word-sync enable from the master lane; 0 disables cross-lane alignment |
| in_code | input | LANES*8 | Decoded character per lane; lane n is bits [8n+7:8n] |
| in_k | input | LANES | Control-character flag per lane |
| in_rdpos | input | LANES | Running-disparity flag per lane, 1 = positive |
| out_code | output | LANES*8 | Deskewed character per lane |
| out_k | output | LANES | Deskewed control flag per lane |
| out_rdpos | output | LANES | Deskewed disparity flag per lane |
| aligned | output | 1 | Lanes are aligned by the latest successful repositioning |
| skew_err | output | 1 | One-cycle pulse when sync points fall outside the window |

## Verification
In one cycle the last lane's sync point can arrive at the same moment the skew window closes. Whether the coordinator accepts that lane or declares a skew error is decided in that single cycle. The bench provokes this case by sweeping every combination of 0, 1 and 2 slots of injected delay over the four lanes. A spread of exactly one slot places the late arrival on the closing cycle, and a spread of two slots arrives one cycle too late. Each case is judged from the ports: the expected tap of each lane is derived arithmetically from the injected delays, each lane's output is compared with the character it must carry, and the `skew_err` pulses and the `aligned` level are compared with what the spread dictates.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

    // One decoded character as carried through the lane delay lines.
    typedef struct packed {
        logic [7:0] code;
        logic       is_k;
        logic       rd_pos;
    } sym_t;

    localparam logic [7:0] COMMA_CODE = 8'hBC;
    localparam int         SYNC_LEN   = 4;

    typedef enum logic [1:0] {
        WIN_IDLE,
        WIN_OPEN,
        WIN_HOLD
    } win_state_e;

    function automatic logic is_comma(sym_t s);
        return s.is_k && (s.code == COMMA_CODE);
    endfunction

    // oldest .. newest: two of one disparity, then two of the other
    function automatic logic sync_match(sym_t o3, sym_t o2, sym_t o1, sym_t o0);
        logic all_comma;
        all_comma = is_comma(o3) && is_comma(o2) && is_comma(o1) && is_comma(o0);
        return all_comma && (o3.rd_pos == o2.rd_pos) && (o1.rd_pos == o0.rd_pos)
               && (o3.rd_pos != o1.rd_pos);
    endfunction

endpackage

// File: rtl/lane_delay_line.sv
module lane_delay_line
    import deskew_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TAP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  sym_t                     wr_sym,
    input  logic [TAP_W-1:0]         rd_tap,
    output sym_t                     rd_sym,
    output sym_t [SYNC_LEN-1:0]      recent
);
    sym_t [DEPTH-1:0] line;

    always_ff @(posedge clk) begin
        if (rst) begin
            line   <= '0;
            rd_sym <= '0;
        end else begin
            line   <= {line[DEPTH-2:0], wr_sym};
            rd_sym <= line[rd_tap];
        end
    end

    // Entry 0 holds the newest character.
    assign recent = line[SYNC_LEN-1:0];

endmodule

// File: rtl/sync_point_det.sv
module sync_point_det
    import deskew_pkg::*;
(
    input  sym_t [SYNC_LEN-1:0] recent,
    output logic                hit
);
    always_comb begin
        hit = sync_match(recent[3], recent[2], recent[1], recent[0]);
    end
endmodule

// File: rtl/deskew_ctrl.sv
module deskew_ctrl
    import deskew_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int SKEW_SLOTS = 1,
    parameter int HOLD_SLOTS = 4,
    parameter int TAP_W      = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         align_en,
    input  logic [LANES-1:0]             hit,
    output logic [LANES-1:0][TAP_W-1:0]  taps,
    output logic                         aligned,
    output logic                         skew_err
);
    localparam int OFF_W  = (SKEW_SLOTS < 1) ? 1 : $clog2(SKEW_SLOTS + 1);
    localparam int HOLD_W = $clog2(HOLD_SLOTS + 1);

    win_state_e                      state;
    logic [LANES-1:0]                seen;
    logic [LANES-1:0][OFF_W-1:0]     arr;
    logic [OFF_W-1:0]                cnt;
    logic [HOLD_W-1:0]               hold;

    logic [OFF_W-1:0]                cur_off;
    logic                            open_win;
    logic                            live;
    logic [LANES-1:0]                seen_n;
    logic [LANES-1:0][OFF_W-1:0]     arr_n;
    logic [LANES-1:0][TAP_W-1:0]     tap_n;
    logic                            done;
    logic                            expire;

    always_comb begin
        cur_off  = (state == WIN_OPEN) ? cnt + OFF_W'(1) : '0;
        open_win = (state == WIN_IDLE) && align_en && (|hit);
        live     = ((state == WIN_OPEN) && align_en) || open_win;
        seen_n   = ((state == WIN_OPEN) ? seen : '0) | hit;
        for (int i = 0; i < LANES; i++) begin
            if (hit[i] && !((state == WIN_OPEN) && seen[i])) begin
                arr_n[i] = cur_off;
            end else begin
                arr_n[i] = (state == WIN_OPEN) ? arr[i] : '0;
            end
            tap_n[i] = TAP_W'(cur_off - arr_n[i]);
        end
        done   = live && (&seen_n);
        expire = live && !(&seen_n) && (cur_off >= OFF_W'(SKEW_SLOTS));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= WIN_IDLE;
            seen     <= '0;
            arr      <= '0;
            cnt      <= '0;
            hold     <= '0;
            taps     <= '0;
            aligned  <= 1'b0;
            skew_err <= 1'b0;
        end else begin
            skew_err <= 1'b0;
            if (done) begin
                taps    <= tap_n;
                aligned <= 1'b1;
                state   <= WIN_IDLE;
                seen    <= '0;
            end else if (expire) begin
                skew_err <= 1'b1;
                aligned  <= 1'b0;
                state    <= WIN_HOLD;
                seen     <= '0;
                hold     <= HOLD_W'(HOLD_SLOTS - 1);
            end else if (live) begin
                state <= WIN_OPEN;
                seen  <= seen_n;
                arr   <= arr_n;
                cnt   <= cur_off;
            end else if (state == WIN_OPEN) begin
                state <= WIN_IDLE;
                seen  <= '0;
            end else if (state == WIN_HOLD) begin
                if (hold == '0) begin
                    state <= WIN_IDLE;
                end else begin
                    hold <= hold - HOLD_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/sync_deskew.sv
module sync_deskew
    import deskew_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int DEPTH      = 4,
    parameter int SKEW_SLOTS = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               align_en,
    input  logic [LANES*8-1:0] in_code,
    input  logic [LANES-1:0]   in_k,
    input  logic [LANES-1:0]   in_rdpos,
    output logic [LANES*8-1:0] out_code,
    output logic [LANES-1:0]   out_k,
    output logic [LANES-1:0]   out_rdpos,
    output logic               aligned,
    output logic               skew_err
);
    localparam int TAP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [LANES-1:0]             lane_hit;
    logic [LANES-1:0][TAP_W-1:0]  tap_sel;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sym_t                  wr_s;
        sym_t                  rd_s;
        sym_t [SYNC_LEN-1:0]   win;

        assign wr_s = '{code: in_code[g*8 +: 8], is_k: in_k[g], rd_pos: in_rdpos[g]};

        lane_delay_line #(.DEPTH(DEPTH), .TAP_W(TAP_W)) line_i (
            .clk    (clk),
            .rst    (rst),
            .wr_sym (wr_s),
            .rd_tap (tap_sel[g]),
            .rd_sym (rd_s),
            .recent (win)
        );

        sync_point_det det_i (
            .recent (win),
            .hit    (lane_hit[g])
        );

        assign out_code[g*8 +: 8] = rd_s.code;
        assign out_k[g]           = rd_s.is_k;
        assign out_rdpos[g]       = rd_s.rd_pos;
    end

    deskew_ctrl #(
        .LANES      (LANES),
        .SKEW_SLOTS (SKEW_SLOTS),
        .HOLD_SLOTS (DEPTH),
        .TAP_W      (TAP_W)
    ) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .align_en (align_en),
        .hit      (lane_hit),
        .taps     (tap_sel),
        .aligned  (aligned),
        .skew_err (skew_err)
    );

endmodule

// File: rtl/sync_deskew_chk.sv
module sync_deskew_chk #(
    parameter int LANES = 4,
    parameter int TAP_W = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     align_en,
    input logic                     aligned,
    input logic                     skew_err,
    input logic [LANES*TAP_W-1:0]   taps
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!aligned && !skew_err));

    // R5
    err_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        skew_err |=> !skew_err);

    // R5
    err_keeps_taps_chk: assert property (@(posedge clk) disable iff (rst)
        skew_err |-> $stable(taps));

    // R5
    err_drops_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        skew_err |-> !aligned);

    // R4
    tap_move_sets_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(taps) |-> aligned);

    // R6
    rise_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(aligned) |-> $past(align_en));

    // R6
    err_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        skew_err |-> $past(align_en));

endmodule

bind sync_deskew sync_deskew_chk #(.LANES(LANES), .TAP_W(TAP_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .align_en (align_en),
    .aligned  (aligned),
    .skew_err (skew_err),
    .taps     (tap_sel)
);

// File: tb/sync_deskew_tb_top.sv
module sync_deskew_tb_top;
    localparam int NL   = 4;
    localparam int SKEW = 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            align_en = 1'b0;
    logic [NL*8-1:0] in_code = '0;
    logic [NL-1:0]   in_k = '0;
    logic [NL-1:0]   in_rdpos = '0;
    logic [NL*8-1:0] out_code;
    logic [NL-1:0]   out_k;
    logic [NL-1:0]   out_rdpos;
    logic            aligned;
    logic            skew_err;

    always #4 clk = ~clk;

    sync_deskew #(.LANES(NL), .DEPTH(4), .SKEW_SLOTS(SKEW)) dut_i (
        .clk(clk), .rst(rst), .align_en(align_en),
        .in_code(in_code), .in_k(in_k), .in_rdpos(in_rdpos),
        .out_code(out_code), .out_k(out_k), .out_rdpos(out_rdpos),
        .aligned(aligned), .skew_err(skew_err)
    );

    int total = 0;
    int bad = 0;
    int stp = 0;
    int errs_seen = 0;
    int d [NL];
    int tap_e [NL];
    bit al_e = 1'b0;
    logic [9:0] hist [8];

    always @(negedge clk) if (!rst && skew_err === 1'b1) errs_seen++;

    task automatic check_int(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] c, input logic k, input logic r);
        @(negedge clk);
        hist[stp % 8] = {c, k, r};
        for (int i = 0; i < NL; i++) begin
            int idx;
            idx = (stp + 8 - d[i]) % 8;
            in_code[i*8 +: 8] = hist[idx][9:2];
            in_k[i]           = hist[idx][1];
            in_rdpos[i]       = hist[idx][0];
        end
        stp++;
    endtask

    // kind: 0 = 1,1,0,0  1 = 0,0,1,1  2 = four positive commas  3 = BC as data
    task automatic run_trial(input int kind, input bit en);
        int mx, mn, e0, exp_err, m;
        logic r;
        mx = d[0]; mn = d[0];
        for (int i = 1; i < NL; i++) begin
            if (d[i] > mx) mx = d[i];
            if (d[i] < mn) mn = d[i];
        end
        exp_err = 0;
        if (kind < 2 && en) begin
            if (mx - mn <= SKEW) begin
                for (int i = 0; i < NL; i++) tap_e[i] = mx - d[i];
                al_e = 1'b1;
            end else begin
                al_e = 1'b0;
                exp_err = 1;
            end
        end
        align_en = en;
        e0 = errs_seen;
        for (int j = 0; j < 6; j++) step(8'(stp), 1'b0, 1'b0);
        r = (kind == 1) ? 1'b0 : 1'b1;
        for (int j = 0; j < 4; j++) begin
            logic rr;
            rr = (kind == 2) ? 1'b1 : ((j < 2) ? r : ~r);
            step(8'hBC, (kind != 3), rr);
        end
        for (int j = 0; j < 8; j++) step(8'hBC, 1'b1, (j % 2 == 0) ? r : ~r);
        for (int j = 0; j < 14; j++) step(8'(stp), 1'b0, 1'b0);
        m = stp - 1;
        for (int i = 0; i < NL; i++) begin
            check_int($sformatf("R7 lane%0d data (d=%0d tap=%0d)", i, d[i], tap_e[i]),
                      int'(out_code[i*8 +: 8]), (m - 2 - d[i] - tap_e[i]) & 255);
        end
        if (kind < 2 && en && exp_err == 0) begin
            for (int i = 1; i < NL; i++)
                check_int($sformatf("R3 lane%0d matches lane0", i),
                          int'(out_code[i*8 +: 8]), int'(out_code[7:0]));
        end
        check_int("R7 k flags clear on data", int'(out_k), 0);
        check_int(en ? (kind >= 2 ? "R2 aligned level" : "R4 aligned level") : "R6 aligned level",
                  int'(aligned), int'(al_e));
        check_int(en ? (kind >= 2 ? "R2 error pulses" : "R5 error pulses") : "R6 error pulses",
                  errs_seen - e0, exp_err);
    endtask

    initial begin
        for (int i = 0; i < NL; i++) begin d[i] = 0; tap_e[i] = 0; end
        for (int i = 0; i < 8; i++) hist[i] = '0;
        repeat (3) @(negedge clk);
        check_int("R1 code in reset", int'(out_code), 0);
        check_int("R1 aligned in reset", int'(aligned), 0);
        rst = 1'b0;
        @(negedge clk);
        check_int("R1 code after reset", int'(out_code), 0);
        check_int("R1 flags after reset", int'({out_k, out_rdpos}), 0);
        check_int("R1 aligned after reset", int'(aligned), 0);
        check_int("R1 skew_err after reset", int'(skew_err), 0);

        run_trial(0, 1'b0);                 // R7 with zero taps, R6
        d[0] = 1; d[2] = 1;
        run_trial(0, 1'b0);                 // R6: pattern ignored
        for (int c = 0; c < 81; c++) begin  // R3 R4 R5: full delay sweep
            int v;
            v = c;
            for (int i = 0; i < NL; i++) begin d[i] = v % 3; v = v / 3; end
            run_trial(c % 2, 1'b1);
        end
        d[0] = 0; d[1] = 1; d[2] = 0; d[3] = 1;
        run_trial(0, 1'b1);
        d[0] = 1; d[1] = 0; d[2] = 1; d[3] = 0;
        run_trial(2, 1'b1);                 // R2 one disparity only
        run_trial(3, 1'b1);                 // R2 BC without control flag
        d[1] = 2;
        run_trial(1, 1'b0);                 // R6 with out-of-window spread

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule